// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block serves one PCI function's message-signalled interrupts across a parameterised number of vectors. Software programs each vector's message address, message data and per-vector mask through a 32-bit table port. It can also read a pending-bit array through a second 32-bit port that ignores writes, and it sets the function-wide enable and mask-all bits through a 16-bit control port. Device logic declares which vectors it actually uses, with per-vector use and unuse pulses that drive a saturating usage count. It raises interrupts with per-vector notify pulses.

A notify on a vector that is in use either leaves at once as a 64-bit address and 32-bit data message on a valid/ready output, or, if the vector is effectively masked, is recorded as a pending bit. When a vector becomes unmasked with its pending bit set, the bit is cleared and the owed message is sent. An unmask through the per-vector mask bit is handled in the same cycle. An unmask of the whole function starts a scan that visits one vector per clock. During that scan the block holds `req_ready` low, and table writes, control writes, notifies and use/unuse pulses are not accepted. Pending replays win over fresh notifies when both wait for the output. A control write that sets enable produces a one-cycle pulse telling the legacy pin interrupt logic to release its line.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, enable and mask-all read 0, the control register reads N-1 in bits [10:0], every vector-control word reads 1 (masked), every pending word reads 0, `msg_valid` is low and `req_ready` is high.
- R2: The table word at index 4*v+k holds vector v's address bits [31:0] for k=0, address bits [63:32] for k=1, message data for k=2, and vector control for k=3. Bit 0 of vector control is the per-vector mask, and its other bits read 0. Written words read back unchanged.
- R3: A notify on a vector whose usage count is zero produces no message and leaves its pending bit clear.
- R4: A notify on an in-use vector that is effectively masked sets pending bit v mod 32 of pending word v/32 and produces no message.
- R5: A notify on an in-use, unmasked vector produces one message carrying that vector's table address and data.
- R6: Clearing a vector's mask bit while its pending bit is set clears the pending bit and produces exactly one message. Setting a mask bit produces no message.
- R7: A vector is effectively masked when its mask bit is set, enable is 0 or mask-all is 1. When a control write takes the function from masked to unmasked, every pending vector with a clear mask bit is replayed in ascending vector order, and `req_ready` is low in the cycle after that write.
- R8: Writes to the pending port leave the pending bits unchanged.
- R9: Control bit 15 is enable and bit 14 is mask-all. A control write with bit 15 set produces `intx_deassert` high for the single following cycle.
- R10: A use pulse increments the usage count, saturating at its maximum. An unuse pulse decrements it and never goes below zero. A decrement that reaches zero clears the vector's pending bit.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. At most one message is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_addr | input | clog2(NVEC)+2 | Table word index (vector*4 + word) |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data for tbl_addr |
| pba_addr | input | PAW | Pending word index |
| pba_wr_en | input | 1 | Pending write strobe (ignored) |
| pba_wdata | input | 32 | Pending write data (ignored) |
| pba_rdata | output | 32 | Pending bits for pba_addr |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 16 | Control register readback |
| vec_use | input | NVEC | Per-vector usage increment |
| vec_unuse | input | NVEC | Per-vector usage decrement |
| notify_req | input | NVEC | Per-vector interrupt request |
| req_ready | output | 1 | Low while a function-unmask scan runs |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| intx_deassert | output | 1 | One-cycle release pulse for pin interrupt |

## Verification
Notifies are tried on vectors that are unused, entry-masked, function-masked and fully unmasked. Each case must be told apart from the others by whether a message appears and whether a pending bit lands in the right word position. Unmask events are driven both per vector and function-wide with several vectors pending, to show that replay clears exactly the pending bits that became unmasked and that it sends them in vector order. A random phase mixes table writes, control values, use/unuse pulses and notifies against a bench model of masks, counts and pending bits, comparing every delivered message and the pending word after each step. A stalled consumer checks that the output holds, and a pending-port write and an unuse-to-zero check that the pending bits change only through their own paths.

// File: rtl/msix_ctl_pkg.sv
package msix_ctl_pkg;
  typedef enum logic [1:0] {
    WD_ADDR_LO = 2'd0,
    WD_ADDR_HI = 2'd1,
    WD_DATA    = 2'd2,
    WD_VCTRL   = 2'd3
  } tbl_word_e;

  localparam int CTL_EN_BIT   = 15;
  localparam int CTL_MALL_BIT = 14;
  localparam int QSIZE_W      = 11;

  // function-level mask: disabled or mask-all set
  function automatic logic func_masked(input logic en, input logic mall);
    return !en || mall;
  endfunction

  function automatic logic [15:0] ctl_image(input logic en, input logic mall,
                                            input int unsigned nvec);
    logic [15:0] r;
    r = '0;
    r[CTL_EN_BIT]     = en;
    r[CTL_MALL_BIT]   = mall;
    r[QSIZE_W-1:0]    = QSIZE_W'(nvec - 1);
    return r;
  endfunction

  // pending array rounded up to 64 bits, counted in 32-bit words
  function automatic int unsigned pba_dwords(input int unsigned nvec);
    return ((nvec + 63) / 64) * 2;
  endfunction
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
  import msix_ctl_pkg::*;
#(
  parameter int NVEC = 8,
  parameter int VW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [VW+1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [VW-1:0]   sel_vec,
  output logic [63:0]     sel_addr,
  output logic [31:0]     sel_data,
  output logic [NVEC-1:0] vmask,
  output logic [NVEC-1:0] unmask_evt
);
  logic [VW-1:0] a_vec;
  tbl_word_e     a_word;
  logic          a_ok;

  assign a_vec  = addr[VW+1:2];
  assign a_word = tbl_word_e'(addr[1:0]);
  assign a_ok   = (32'(a_vec) < 32'(NVEC));

  logic [NVEC-1:0][31:0] lo_all, hi_all, dat_all;

  for (genvar v = 0; v < NVEC; v++) begin : g_ent
    logic [31:0] lo_q, hi_q, dat_q;
    logic        msk_q;
    logic        hit;

    assign hit = wr_en && a_ok && (a_vec == VW'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        dat_q <= '0;
        msk_q <= 1'b1;
      end else if (hit) begin
        case (a_word)
          WD_ADDR_LO: lo_q  <= wdata;
          WD_ADDR_HI: hi_q  <= wdata;
          WD_DATA:    dat_q <= wdata;
          default:    msk_q <= wdata[0];
        endcase
      end
    end

    assign lo_all[v]     = lo_q;
    assign hi_all[v]     = hi_q;
    assign dat_all[v]    = dat_q;
    assign vmask[v]      = msk_q;
    assign unmask_evt[v] = hit && (a_word == WD_VCTRL) && msk_q && !wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (a_ok) begin
      case (a_word)
        WD_ADDR_LO: rdata = lo_all[a_vec];
        WD_ADDR_HI: rdata = hi_all[a_vec];
        WD_DATA:    rdata = dat_all[a_vec];
        default:    rdata = {31'd0, vmask[a_vec]};
      endcase
    end
  end

  assign sel_addr = {hi_all[sel_vec], lo_all[sel_vec]};
  assign sel_data = dat_all[sel_vec];

  // R2: a vector-control write lands in the mask bit one cycle later
  assert_vctrl_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && a_ok && a_word == WD_VCTRL) |=> vmask[$past(a_vec)] == $past(wdata[0]));
endmodule

// File: rtl/msix_use_cnt.sv
module msix_use_cnt #(
  parameter int NVEC  = 8,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] inc,
  input  logic [NVEC-1:0] dec,
  output logic [NVEC-1:0] in_use,
  output logic [NVEC-1:0] drain
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar v = 0; v < NVEC; v++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic             up, dn;

    assign up = inc[v] && !dec[v] && (cnt_q != CNT_MAX);
    assign dn = dec[v] && !inc[v] && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (up)  cnt_q <= cnt_q + 1'b1;
      else if (dn)  cnt_q <= cnt_q - 1'b1;
    end

    assign in_use[v] = (cnt_q != '0);
    assign drain[v]  = dn && (cnt_q == CNT_W'(1));

    // R10: an unuse on an idle vector keeps it idle
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !inc[v]) |=> cnt_q == '0);
  end
endmodule

// File: rtl/msix_pend_ctl.sv
module msix_pend_ctl #(
  parameter int NVEC = 8,
  parameter int VW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fmask,
  input  logic [NVEC-1:0] vmask,
  input  logic            fm_drop,
  input  logic [NVEC-1:0] unmask_evt,
  input  logic [NVEC-1:0] ntf_acc,
  input  logic [NVEC-1:0] in_use,
  input  logic [NVEC-1:0] drain,
  input  logic            launch_fire,
  input  logic [VW-1:0]   launch_vec,
  input  logic            launch_to_pend,
  output logic [NVEC-1:0] pend,
  output logic [NVEC-1:0] rep_q,
  output logic [NVEC-1:0] ntf_q,
  output logic            scan_busy
);
  logic          scan_on;
  logic [VW-1:0] scan_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_on  <= 1'b0;
      scan_idx <= '0;
    end else if (fm_drop) begin
      scan_on  <= 1'b1;
      scan_idx <= '0;
    end else if (scan_on) begin
      if (scan_idx == VW'(NVEC - 1)) scan_on <= 1'b0;
      scan_idx <= scan_idx + 1'b1;
    end
  end

  assign scan_busy = scan_on;

  logic [NVEC-1:0] rep_set;

  for (genvar v = 0; v < NVEC; v++) begin : g_vec
    logic eff, l_hit, scan_hit, ent_hit, p_set, p_clr;

    assign eff      = fmask || vmask[v];
    assign l_hit    = launch_fire && (launch_vec == VW'(v));
    assign scan_hit = scan_on && (scan_idx == VW'(v)) && !fmask && !vmask[v] && pend[v];
    assign ent_hit  = unmask_evt[v] && !fmask && pend[v];
    assign rep_set[v] = scan_hit || ent_hit;
    assign p_set    = (ntf_acc[v] && eff) || (l_hit && launch_to_pend);
    assign p_clr    = rep_set[v] || drain[v];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[v]  <= 1'b0;
        rep_q[v] <= 1'b0;
        ntf_q[v] <= 1'b0;
      end else begin
        pend[v]  <= (pend[v] || p_set) && !p_clr;
        rep_q[v] <= ((rep_q[v] && !l_hit) || rep_set[v]) && !drain[v];
        ntf_q[v] <= ((ntf_q[v] && !l_hit) || (ntf_acc[v] && !eff)) && !drain[v];
      end
    end

    // R6: a replay consumes the pending bit
    assert_replay_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rep_set[v] |=> !pend[v]);
    // R10: an unused vector never holds a pending bit
    assert_idle_no_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_use[v] |-> !pend[v]);
  end
endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out #(
  parameter int NVEC = 8,
  parameter int VW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] rep_q,
  input  logic [NVEC-1:0] ntf_q,
  input  logic [NVEC-1:0] eff_mask,
  output logic [VW-1:0]   sel_vec,
  input  logic [63:0]     sel_addr,
  input  logic [31:0]     sel_data,
  input  logic            msg_ready,
  output logic            msg_valid,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data,
  output logic            launch_fire,
  output logic [VW-1:0]   launch_vec,
  output logic            launch_to_pend
);
  function automatic logic [VW-1:0] first_set(input logic [NVEC-1:0] b);
    logic [VW-1:0] r;
    r = '0;
    for (int i = NVEC - 1; i >= 0; i--) if (b[i]) r = VW'(i);
    return r;
  endfunction

  logic          cand;
  logic [VW-1:0] pick;

  assign cand           = (|rep_q) || (|ntf_q);
  assign pick           = (|rep_q) ? first_set(rep_q) : first_set(ntf_q);
  assign sel_vec        = pick;
  assign launch_vec     = pick;
  assign launch_fire    = cand && !msg_valid;
  assign launch_to_pend = eff_mask[pick];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (launch_fire && !launch_to_pend) begin
      msg_valid <= 1'b1;
      msg_addr  <= sel_addr;
      msg_data  <= sel_data;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R11: a stalled message holds its contents
  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  // R11: a consumed message leaves a gap, so only one is outstanding
  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_ctl_pkg::*;
#(
  parameter int NVEC  = 8,
  parameter int CNT_W = 4,
  localparam int VW       = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int TAW      = VW + 2,
  localparam int PBA_DW   = pba_dwords(NVEC),
  localparam int PAW      = (PBA_DW > 1) ? $clog2(PBA_DW) : 1,
  localparam int PBA_BITS = PBA_DW * 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tbl_wr_en,
  input  logic [TAW-1:0]  tbl_addr,
  input  logic [31:0]     tbl_wdata,
  output logic [31:0]     tbl_rdata,
  input  logic [PAW-1:0]  pba_addr,
  input  logic            pba_wr_en,
  input  logic [31:0]     pba_wdata,
  output logic [31:0]     pba_rdata,
  input  logic            ctl_wr_en,
  input  logic [15:0]     ctl_wdata,
  output logic [15:0]     ctl_rdata,
  input  logic [NVEC-1:0] vec_use,
  input  logic [NVEC-1:0] vec_unuse,
  input  logic [NVEC-1:0] notify_req,
  output logic            req_ready,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data,
  output logic            intx_deassert
);
  logic ctl_en, ctl_mall, fmask, ctl_acc, new_fm, fm_drop, scan_busy;
  logic [NVEC-1:0] vmask, unmask_evt, in_use, drain, ntf_acc, eff_mask;
  logic [NVEC-1:0] pend, rep_q, ntf_q, ready_v;
  logic [VW-1:0]   sel_vec, launch_vec;
  logic [63:0]     sel_addr;
  logic [31:0]     sel_data;
  logic            launch_fire, launch_to_pend;

  assign req_ready = !scan_busy;
  assign ready_v   = {NVEC{req_ready}};
  assign fmask     = func_masked(ctl_en, ctl_mall);
  assign ctl_acc   = ctl_wr_en && req_ready;
  assign new_fm    = func_masked(ctl_wdata[CTL_EN_BIT], ctl_wdata[CTL_MALL_BIT]);
  assign fm_drop   = ctl_acc && fmask && !new_fm;
  assign eff_mask  = vmask | {NVEC{fmask}};
  assign ntf_acc   = notify_req & in_use & ready_v;
  assign ctl_rdata = ctl_image(ctl_en, ctl_mall, NVEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en        <= 1'b0;
      ctl_mall      <= 1'b0;
      intx_deassert <= 1'b0;
    end else begin
      intx_deassert <= ctl_acc && ctl_wdata[CTL_EN_BIT];
      if (ctl_acc) begin
        ctl_en   <= ctl_wdata[CTL_EN_BIT];
        ctl_mall <= ctl_wdata[CTL_MALL_BIT];
      end
    end
  end

  // pending port: reads only
  logic [PBA_BITS-1:0] pend_pad;
  assign pend_pad  = PBA_BITS'(pend);
  assign pba_rdata = (32'(pba_addr) < 32'(PBA_DW)) ? pend_pad[32*int'(pba_addr) +: 32] : '0;

  logic unused_inputs;
  assign unused_inputs = pba_wr_en ^ (^pba_wdata) ^ (^ctl_wdata[13:0]);

  msix_vec_table #(.NVEC(NVEC), .VW(VW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en && req_ready), .addr(tbl_addr), .wdata(tbl_wdata),
    .rdata(tbl_rdata), .sel_vec(sel_vec), .sel_addr(sel_addr),
    .sel_data(sel_data), .vmask(vmask), .unmask_evt(unmask_evt)
  );

  msix_use_cnt #(.NVEC(NVEC), .CNT_W(CNT_W)) u_use (
    .clk(clk), .rst_n(rst_n),
    .inc(vec_use & ready_v), .dec(vec_unuse & ready_v),
    .in_use(in_use), .drain(drain)
  );

  msix_pend_ctl #(.NVEC(NVEC), .VW(VW)) u_pend (
    .clk(clk), .rst_n(rst_n), .fmask(fmask), .vmask(vmask),
    .fm_drop(fm_drop), .unmask_evt(unmask_evt), .ntf_acc(ntf_acc),
    .in_use(in_use), .drain(drain), .launch_fire(launch_fire),
    .launch_vec(launch_vec), .launch_to_pend(launch_to_pend),
    .pend(pend), .rep_q(rep_q), .ntf_q(ntf_q), .scan_busy(scan_busy)
  );

  msix_msg_out #(.NVEC(NVEC), .VW(VW)) u_out (
    .clk(clk), .rst_n(rst_n), .rep_q(rep_q), .ntf_q(ntf_q),
    .eff_mask(eff_mask), .sel_vec(sel_vec), .sel_addr(sel_addr),
    .sel_data(sel_data), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .launch_fire(launch_fire),
    .launch_vec(launch_vec), .launch_to_pend(launch_to_pend)
  );

  // R7: a function unmask stalls the request side in the next cycle
  assert_scan_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fm_drop |=> !req_ready);
  // R9: the pin release pulse follows a control write
  assert_intx_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> $past(ctl_wr_en));
endmodule

// File: tb/msix_vec_ctrl_tb.sv
module msix_vec_ctrl_tb;
  localparam int NVEC = 8;
  localparam int TAW  = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tbl_wr_en, pba_wr_en, ctl_wr_en, req_ready, msg_valid, msg_ready, intx_deassert;
  logic [TAW-1:0] tbl_addr;
  logic [31:0] tbl_wdata, tbl_rdata, pba_wdata, pba_rdata, msg_data;
  logic [0:0] pba_addr;
  logic [15:0] ctl_wdata, ctl_rdata;
  logic [NVEC-1:0] vec_use, vec_unuse, notify_req;
  logic [63:0] msg_addr;

  msix_vec_ctrl #(.NVEC(NVEC), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_wr_en(tbl_wr_en), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .pba_addr(pba_addr),
    .pba_wr_en(pba_wr_en), .pba_wdata(pba_wdata), .pba_rdata(pba_rdata),
    .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .vec_use(vec_use), .vec_unuse(vec_unuse), .notify_req(notify_req),
    .req_ready(req_ready), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .intx_deassert(intx_deassert)
  );

  int tests = 0, fails = 0;
  int e_n = 0, rx_n = 0, seen = 0;
  logic [63:0] e_addr[1024], rx_addr[1024];
  logic [31:0] e_data[1024], rx_data[1024];
  logic [31:0] m_lo[NVEC], m_hi[NVEC], m_dat[NVEC];
  logic m_vm[NVEC], m_pend[NVEC];
  int   m_cnt[NVEC];
  logic m_en, m_mall, last_intx, last_ready;

  always @(posedge clk)
    if (rst_n && msg_valid && msg_ready && rx_n < 1024) begin
      rx_addr[rx_n] <= msg_addr;
      rx_data[rx_n] <= msg_data;
      rx_n <= rx_n + 1;
    end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic m_fm();
    return !m_en || m_mall;
  endfunction
  function automatic logic m_eff(input int v);
    return m_vm[v] || m_fm();
  endfunction
  function automatic void m_push(input int v);
    e_addr[e_n] = {m_hi[v], m_lo[v]};
    e_data[e_n] = m_dat[v];
    e_n++;
  endfunction
  function automatic logic [31:0] m_pba_word();
    logic [31:0] r;
    r = '0;
    for (int v = 0; v < NVEC; v++) r[v] = m_pend[v];
    return r;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_tbl_wr(input int v, input int w, input logic [31:0] d);
    logic old;
    tbl_wr_en = 1'b1; tbl_addr = TAW'(v * 4 + w); tbl_wdata = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    case (w)
      0: m_lo[v] = d;
      1: m_hi[v] = d;
      2: m_dat[v] = d;
      default: begin
        old = m_eff(v);
        m_vm[v] = d[0];
        if (old && !m_eff(v) && m_pend[v]) begin m_pend[v] = 1'b0; m_push(v); end
      end
    endcase
  endtask

  task automatic t_tbl_rd(input int v, input int w, output logic [31:0] d);
    tbl_addr = TAW'(v * 4 + w);
    #1 d = tbl_rdata;
  endtask

  task automatic t_ctl(input logic [15:0] val);
    logic old_fm;
    old_fm = m_fm();
    ctl_wr_en = 1'b1; ctl_wdata = val;
    @(negedge clk);
    last_intx = intx_deassert; last_ready = req_ready;
    ctl_wr_en = 1'b0;
    m_en = val[15]; m_mall = val[14];
    if (old_fm && !m_fm())
      for (int v = 0; v < NVEC; v++)
        if (!m_vm[v] && m_pend[v]) begin m_pend[v] = 1'b0; m_push(v); end
  endtask

  task automatic t_notify(input int v);
    notify_req[v] = 1'b1;
    @(negedge clk);
    notify_req = '0;
    if (m_cnt[v] != 0) begin
      if (m_eff(v)) m_pend[v] = 1'b1;
      else m_push(v);
    end
  endtask

  task automatic t_use(input int v);
    vec_use[v] = 1'b1; @(negedge clk); vec_use = '0;
    if (m_cnt[v] < 15) m_cnt[v]++;
  endtask

  task automatic t_unuse(input int v);
    vec_unuse[v] = 1'b1; @(negedge clk); vec_unuse = '0;
    if (m_cnt[v] > 0) begin
      m_cnt[v]--;
      if (m_cnt[v] == 0) m_pend[v] = 1'b0;
    end
  endtask

  task automatic check_msgs(input string req);
    int lim;
    check({req, " count"}, 64'(rx_n), 64'(e_n));
    lim = (rx_n < e_n) ? rx_n : e_n;
    for (int i = seen; i < lim; i++) begin
      check({req, " addr"}, rx_addr[i], e_addr[i]);
      check({req, " data"}, 64'(rx_data[i]), 64'(e_data[i]));
    end
    seen = lim;
  endtask

  task automatic check_pba(input string req);
    pba_addr = 1'b0; #1;
    check(req, 64'(pba_rdata), 64'(m_pba_word()));
    pba_addr = 1'b1; #1;
    check(req, 64'(pba_rdata), 64'd0);
    pba_addr = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] a0;
    logic [31:0] d0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tbl_wr_en = 0; pba_wr_en = 0; ctl_wr_en = 0; msg_ready = 1'b1;
    tbl_addr = '0; tbl_wdata = '0; pba_addr = '0; pba_wdata = '0; ctl_wdata = '0;
    vec_use = '0; vec_unuse = '0; notify_req = '0;
    for (int v = 0; v < NVEC; v++) begin
      m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0; m_vm[v] = 1'b1; m_pend[v] = 1'b0; m_cnt[v] = 0;
    end
    m_en = 0; m_mall = 0;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    check("R1 ctl", 64'(ctl_rdata), 64'h0007);
    check("R1 msg_valid", 64'(msg_valid), 64'd0);
    check("R1 ready", 64'(req_ready), 64'd1);
    for (int v = 0; v < NVEC; v++) begin
      t_tbl_rd(v, 3, rd); check("R1 vctrl", 64'(rd), 64'd1);
    end
    check_pba("R1 pba");

    // R2 table layout and readback
    for (int v = 0; v < NVEC; v++)
      for (int w = 0; w < 3; w++) t_tbl_wr(v, w, $urandom());
    for (int v = 0; v < NVEC; v++) begin
      t_tbl_rd(v, 0, rd); check("R2 addr lo", 64'(rd), 64'(m_lo[v]));
      t_tbl_rd(v, 1, rd); check("R2 addr hi", 64'(rd), 64'(m_hi[v]));
      t_tbl_rd(v, 2, rd); check("R2 data", 64'(rd), 64'(m_dat[v]));
    end
    t_tbl_wr(3, 3, 32'hFFFF_FFFE);
    t_tbl_rd(3, 3, rd); check("R2 vctrl reserved", 64'(rd), 64'd0);
    t_tbl_wr(3, 3, 32'h1);

    // R3 unused vector: dropped
    t_ctl(16'h8000); settle(12);
    t_tbl_wr(1, 3, 32'h0);
    t_notify(1); settle(10);
    check_msgs("R3 unused notify");
    check_pba("R3 pba");

    // R10 unuse at zero stays zero, then use
    t_unuse(1); t_use(1);
    // R4 masked notify -> pending
    t_tbl_wr(1, 3, 32'h1);
    t_notify(1); settle(6);
    check_pba("R4 pending bit");
    check_msgs("R4 no message");

    // R6 entry unmask replays
    t_tbl_wr(1, 3, 32'h0); settle(10);
    check_msgs("R6 replay");
    check_pba("R6 pending cleared");
    // R5 direct notify
    t_notify(1); settle(10);
    check_msgs("R5 direct");
    // R6 masking emits nothing
    t_tbl_wr(1, 3, 32'h1); settle(10);
    check_msgs("R6 mask no msg");

    // R9 / R7 control, mask-all replay order
    t_use(2); t_use(5);
    t_tbl_wr(2, 3, 32'h0); t_tbl_wr(5, 3, 32'h0);
    t_ctl(16'hC000);
    check("R9 ctl readback", 64'(ctl_rdata), 64'hC007);
    t_notify(5); t_notify(2); settle(6);
    check_pba("R7 masked by mask-all");
    t_ctl(16'h8000);
    check("R9 intx pulse", 64'(last_intx), 64'd1);
    check("R7 ready low in scan", 64'(last_ready), 64'd0);
    settle(1);
    check("R9 intx single cycle", 64'(intx_deassert), 64'd0);
    settle(30);
    check_msgs("R7 replay order");
    check_pba("R7 pending cleared");
    t_ctl(16'h0000);
    check("R9 no intx when disabled", 64'(last_intx), 64'd0);
    t_ctl(16'h8000); settle(12);

    // R11 hold under backpressure
    msg_ready = 1'b0;
    t_notify(2); settle(5);
    check("R11 valid", 64'(msg_valid), 64'd1);
    a0 = msg_addr; d0 = msg_data;
    settle(4);
    check("R11 addr held", msg_addr, a0);
    check("R11 data held", 64'(msg_data), 64'(d0));
    check("R11 still valid", 64'(msg_valid), 64'd1);
    msg_ready = 1'b1; settle(6);
    check_msgs("R11 delivered");

    // R8 pending port writes ignored
    t_ctl(16'hC000);
    t_notify(2); settle(4);
    pba_addr = 1'b0; pba_wdata = 32'hFFFF_FFFF; pba_wr_en = 1'b1;
    @(negedge clk); pba_wr_en = 1'b0;
    pba_wdata = 32'h0; pba_wr_en = 1'b1;
    @(negedge clk); pba_wr_en = 1'b0;
    check_pba("R8 write ignored");
    // R10 drain to zero clears pending
    t_unuse(2); settle(2);
    check_pba("R10 drain clears");
    t_ctl(16'h8000); settle(20);
    check_msgs("R10 nothing replayed");

    // random phase
    for (int it = 0; it < 120; it++) begin
      int v, k;
      v = $urandom_range(0, NVEC - 1);
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2, 3: t_notify(v);
        4: t_tbl_wr(v, 3, {31'd0, 1'($urandom_range(0, 1))});
        5: t_tbl_wr(v, $urandom_range(0, 2), $urandom());
        6: case ($urandom_range(0, 3))
             0: t_ctl(16'h0000);
             1: t_ctl(16'h8000);
             2: t_ctl(16'hC000);
             default: t_ctl(16'h4000);
           endcase
        7, 8: t_use(v);
        default: t_unuse(v);
      endcase
      settle(40);
      check_msgs("R5 R7 random");
      check_pba("R4 random");
    end

    summary();
    $finish;
  end
endmodule